// File: doc/BRIEF.md
# I2C Target Controller with Status Flags

This block lets a chip answer on a two-wire serial bus as a target only. It watches a serial clock and a serial data line that a remote controller drives, passes both through synchronizer flops, and recognises START (data falls while the clock is high), STOP (data rises while the clock is high) and repeated START. It never creates any of these framing conditions itself. The first byte after a START carries a 7-bit address and a direction bit. When the address equals `own_addr`, the block acknowledges it and then either receives bytes (write) or sends bytes (read). Data are driven only low, through the output enable `sda_oe`, and only while the clock is low.

A CPU uses the block through a small register-style interface. It loads a transmit holding register with `thr_wr`/`thr_data` and collects received bytes from `rdr_data`, acknowledging each with `rdr_rd`. Seven status flags follow the bus: access, direction, end of access, transmit ready, transmit complete, NACK and receive ready. The target is active only while `tgt_en` is high and `ctl_en` (a request for controller operation) is low. Before use, software programs `own_addr`, holds `ctl_en` low and raises `tgt_en`.

The byte engine is a state machine. ST_IDLE waits for a START. ST_ADDR shifts in the address byte. ST_ADDR_ACK drives the acknowledge for a match; an address that does not match returns to ST_IDLE. ST_WR_BYTE and ST_WR_ACK alternate during a write. During a read, ST_RD_BYTE shifts data out and ST_RD_ACK samples the controller's acknowledge bit. An ACK leads to ST_RD_NEXT, which loads the next byte at the next clock fall. A NACK leads to ST_IDLE. From any state, a START enters ST_ADDR and a STOP enters ST_IDLE. Losing the enable also forces ST_IDLE.

Top module: `i2c_tgt_ctrl`

## Requirements
- R1: After reset, `sda_oe` is 0 and the status flags read as follows: access 0, read 0, eoa 0, txrdy 1, txcomp 1, nack 0, rxrdy 0.
- R2: The first byte after a START is the address, sent MSB first: bits 7..1 are the address and bit 0 is the direction (1 = read). If bits 7..1 equal `own_addr`, the target pulls data low during the ninth clock, `st_access` becomes 1 and `st_read` takes the direction bit. If they do not match, the target gives no acknowledge and `st_access` stays 0.
- R3: In a write access, the target acknowledges every data byte on its ninth clock. It places the byte, MSB first on the bus, in `rdr_data` and sets `st_rxrdy`. A one-cycle `rdr_rd` pulse clears `st_rxrdy`.
- R4: In a read access, the target shifts out the byte taken from the transmit holding register, MSB first. It continues with further bytes while the controller acknowledges. `sda_oe` rises only while the clock is low.
- R5: A `thr_wr` pulse loads the holding register and clears `st_txrdy` on the next cycle. `st_txrdy` is set again once the acknowledge bit after a transmitted byte has been sampled, whether that bit is ACK or NACK.
- R6: If the controller does not acknowledge a transmitted byte, `st_nack` is set and the target releases the data line until the next START. A new matching address clears `st_nack`.
- R7: `st_access` stays 1 until a STOP or a repeated START. It then falls, and `st_eoa` is high for exactly one clock cycle.
- R8: A matching read address clears `st_txcomp`. The end of that read access (STOP or repeated START) sets `st_txcomp` again.
- R9: While `tgt_en` is 0 or `ctl_en` is 1, the target never drives the data line and sets no access flag, even when its own address is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data read back from the bus |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |
| own_addr | input | 7 | Target address |
| tgt_en | input | 1 | Target operation enable |
| ctl_en | input | 1 | Controller-operation request; keeps the target idle while high |
| thr_wr | input | 1 | Write strobe for the transmit holding register |
| thr_data | input | 8 | Byte to transmit |
| rdr_rd | input | 1 | Read strobe for the receive data register |
| rdr_data | output | 8 | Last received byte |
| st_access | output | 1 | Addressed access in progress |
| st_read | output | 1 | Direction of the current or last access (1 = read) |
| st_eoa | output | 1 | One-cycle pulse when an access ends |
| st_txrdy | output | 1 | Holding register may be written |
| st_txcomp | output | 1 | No read access in progress |
| st_nack | output | 1 | Controller did not acknowledge a transmitted byte |
| st_rxrdy | output | 1 | Received byte waiting in `rdr_data` |

## Verification
The bench builds the block with its default two synchronizer stages and an 8-bit data path. It drives the bus with a quarter bit period of ten system clocks. That margin lets the bench refill the holding register inside the high half of the acknowledge clock and still see every acknowledge and data bit settle before it samples them. With these values the bench can exercise repeated START between accesses, a NACK on the last read byte, refilling during multi-byte reads, and both enable conditions. Random addresses, directions, byte counts and data are then mixed across the matching and non-matching cases.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = DATA_W - 1;
    localparam int CNT_W  = $clog2(DATA_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_RD_NEXT
    } tgt_state_e;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_d;
    logic              sda_d;

    // The idle bus is high, so the chains reset to ones.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_i};
            sda_ff <= {sda_ff[STAGES-2:0], sda_i};
            scl_d  <= scl_ff[STAGES-1];
            sda_d  <= sda_ff[STAGES-1];
        end
    end

    assign scl_s     = scl_ff[STAGES-1];
    assign sda_s     = sda_ff[STAGES-1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
    import i2c_tgt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic [DATA_W-1:0] thr_q,
    output logic              sda_oe,
    output logic              ev_match,
    output logic              ev_dir,
    output logic              ev_rx,
    output logic [DATA_W-1:0] rx_byte,
    output logic              ev_acksmp,
    output logic              ev_nack
);
    tgt_state_e        state, nxt;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] rx_sh;
    logic [DATA_W-1:0] tx_sh;
    logic              byte_full;
    logic              addr_hit;

    assign byte_full = (cnt == CNT_W'(DATA_W));
    assign addr_hit  = (rx_sh[DATA_W-1:1] == own_addr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (!active || stop_det) begin
            nxt = ST_IDLE;
        end else if (start_det) begin
            nxt = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE:     nxt = ST_IDLE;
                ST_ADDR:     if (scl_fall && byte_full) nxt = addr_hit ? ST_ADDR_ACK : ST_IDLE;
                ST_ADDR_ACK: if (scl_fall) nxt = rx_sh[0] ? ST_RD_BYTE : ST_WR_BYTE;
                ST_WR_BYTE:  if (scl_fall && byte_full) nxt = ST_WR_ACK;
                ST_WR_ACK:   if (scl_fall) nxt = ST_WR_BYTE;
                ST_RD_BYTE:  if (scl_fall && byte_full) nxt = ST_RD_ACK;
                ST_RD_ACK:   if (scl_rise) nxt = sda_s ? ST_IDLE : ST_RD_NEXT;
                ST_RD_NEXT:  if (scl_fall) nxt = ST_RD_BYTE;
                default:     nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            sda_oe    <= 1'b0;
            ev_match  <= 1'b0;
            ev_dir    <= 1'b0;
            ev_rx     <= 1'b0;
            rx_byte   <= '0;
            ev_acksmp <= 1'b0;
            ev_nack   <= 1'b0;
        end else begin
            ev_match  <= 1'b0;
            ev_rx     <= 1'b0;
            ev_acksmp <= 1'b0;
            ev_nack   <= 1'b0;
            if (!active || stop_det || start_det) begin
                sda_oe <= 1'b0;
                cnt    <= '0;
            end else begin
                unique case (state)
                    ST_IDLE: sda_oe <= 1'b0;
                    ST_ADDR, ST_WR_BYTE: begin
                        if (scl_rise) begin
                            rx_sh <= {rx_sh[DATA_W-2:0], sda_s};
                            cnt   <= cnt + 1'b1;
                        end
                        if (scl_fall && byte_full) begin
                            if (state == ST_WR_BYTE) begin
                                sda_oe  <= 1'b1;
                                ev_rx   <= 1'b1;
                                rx_byte <= rx_sh;
                            end else if (addr_hit) begin
                                sda_oe   <= 1'b1;
                                ev_match <= 1'b1;
                                ev_dir   <= rx_sh[0];
                            end
                        end
                    end
                    ST_ADDR_ACK, ST_WR_ACK: begin
                        if (scl_fall) begin
                            cnt <= '0;
                            if (state == ST_ADDR_ACK && rx_sh[0]) begin
                                tx_sh  <= thr_q;
                                sda_oe <= ~thr_q[DATA_W-1];
                            end else begin
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    ST_RD_BYTE: begin
                        if (scl_rise) cnt <= cnt + 1'b1;
                        if (scl_fall) begin
                            if (byte_full) begin
                                sda_oe <= 1'b0;
                            end else begin
                                tx_sh  <= tx_sh << 1;
                                sda_oe <= ~tx_sh[DATA_W-2];
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise) begin
                            ev_acksmp <= 1'b1;
                            ev_nack   <= sda_s;
                        end
                    end
                    ST_RD_NEXT: begin
                        if (scl_fall) begin
                            tx_sh  <= thr_q;
                            sda_oe <= ~thr_q[DATA_W-1];
                            cnt    <= '0;
                        end
                    end
                    default: sda_oe <= 1'b0;
                endcase
            end
        end
    end

    // R4: the data line is only pulled low while the clock is low
    assert_oe_rise_scl_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);

    // R9: a disabled target stays off the bus and reports no match
    assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (!sda_oe && !ev_match));
endmodule

// File: rtl/i2c_tgt_flags.sv
module i2c_tgt_flags
    import i2c_tgt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_end,
    input  logic              ev_match,
    input  logic              ev_dir,
    input  logic              ev_rx,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              ev_acksmp,
    input  logic              ev_nack,
    input  logic              thr_wr,
    input  logic [DATA_W-1:0] thr_data,
    input  logic              rdr_rd,
    output logic [DATA_W-1:0] thr_q,
    output logic [DATA_W-1:0] rdr_data,
    output logic              access,
    output logic              read,
    output logic              eoa,
    output logic              txrdy,
    output logic              txcomp,
    output logic              nack,
    output logic              rxrdy
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thr_q    <= '0;
            rdr_data <= '0;
            access   <= 1'b0;
            read     <= 1'b0;
            eoa      <= 1'b0;
            txrdy    <= 1'b1;
            txcomp   <= 1'b1;
            nack     <= 1'b0;
            rxrdy    <= 1'b0;
        end else begin
            eoa <= 1'b0;
            if (frame_end && access) begin
                access <= 1'b0;
                eoa    <= 1'b1;
                if (read) txcomp <= 1'b1;
            end
            if (ev_match) begin
                access <= 1'b1;
                read   <= ev_dir;
                nack   <= 1'b0;
                if (ev_dir) txcomp <= 1'b0;
            end
            if (ev_nack) nack <= 1'b1;
            if (thr_wr) begin
                thr_q <= thr_data;
                txrdy <= 1'b0;
            end else if (ev_acksmp) begin
                txrdy <= 1'b1;
            end
            if (ev_rx) begin
                rdr_data <= rx_byte;
                rxrdy    <= 1'b1;
            end else if (rdr_rd) begin
                rxrdy <= 1'b0;
            end
        end
    end

    // R5: a holding register write leaves transmit-ready low
    assert_txrdy_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        thr_wr |=> !txrdy);

    // R7: end of access is reported only as access drops
    assert_eoa_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        eoa |-> (!access && $past(access)));

    // R3: a receive register read clears receive-ready
    assert_rxrdy_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rdr_rd && !ev_rx) |=> !rxrdy);
endmodule

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl
    import i2c_tgt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              tgt_en,
    input  logic              ctl_en,
    input  logic              thr_wr,
    input  logic [DATA_W-1:0] thr_data,
    input  logic              rdr_rd,
    output logic [DATA_W-1:0] rdr_data,
    output logic              st_access,
    output logic              st_read,
    output logic              st_eoa,
    output logic              st_txrdy,
    output logic              st_txcomp,
    output logic              st_nack,
    output logic              st_rxrdy
);
    logic              active;
    logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              ev_match, ev_dir, ev_rx, ev_acksmp, ev_nack;
    logic [DATA_W-1:0] rx_byte;
    logic [DATA_W-1:0] thr_q;

    assign active = tgt_en & ~ctl_en;

    i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_tgt_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .active(active), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
        .stop_det(stop_det), .own_addr(own_addr), .thr_q(thr_q), .sda_oe(sda_oe),
        .ev_match(ev_match), .ev_dir(ev_dir), .ev_rx(ev_rx), .rx_byte(rx_byte),
        .ev_acksmp(ev_acksmp), .ev_nack(ev_nack)
    );

    i2c_tgt_flags u_flags (
        .clk(clk), .rst_n(rst_n), .frame_end((start_det | stop_det) & active),
        .ev_match(ev_match), .ev_dir(ev_dir), .ev_rx(ev_rx), .rx_byte(rx_byte),
        .ev_acksmp(ev_acksmp), .ev_nack(ev_nack), .thr_wr(thr_wr),
        .thr_data(thr_data), .rdr_rd(rdr_rd), .thr_q(thr_q), .rdr_data(rdr_data),
        .access(st_access), .read(st_read), .eoa(st_eoa), .txrdy(st_txrdy),
        .txcomp(st_txcomp), .nack(st_nack), .rxrdy(st_rxrdy)
    );

    // R2: a new access is always accompanied by the address acknowledge
    assert_access_acked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_access) |-> sda_oe);
endmodule

// File: tb/i2c_tgt_ctrl_test.sv
module i2c_tgt_ctrl_test;
    localparam int CLK_NS = 10;
    localparam int Q = 10;
    localparam int WD_LIMIT = 150000;
    localparam logic [6:0] OWN = 7'h3A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_bus;
    logic       sda_oe;
    logic [6:0] own_addr = OWN;
    logic       tgt_en = 1'b1;
    logic       ctl_en = 1'b0;
    logic       thr_wr = 1'b0;
    logic [7:0] thr_data = 8'h00;
    logic       rdr_rd = 1'b0;
    logic [7:0] rdr_data;
    logic       st_access, st_read, st_eoa, st_txrdy, st_txcomp, st_nack, st_rxrdy;

    int tests = 0;
    int fails = 0;
    int eoa_rises = 0;
    int eoa_cycles = 0;
    logic eoa_prev = 1'b0;
    bit done = 1'b0;

    assign sda_bus = sda_m & ~sda_oe;

    always #(CLK_NS/2) clk = ~clk;

    i2c_tgt_ctrl uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
        .own_addr(own_addr), .tgt_en(tgt_en), .ctl_en(ctl_en), .thr_wr(thr_wr),
        .thr_data(thr_data), .rdr_rd(rdr_rd), .rdr_data(rdr_data),
        .st_access(st_access), .st_read(st_read), .st_eoa(st_eoa),
        .st_txrdy(st_txrdy), .st_txcomp(st_txcomp), .st_nack(st_nack),
        .st_rxrdy(st_rxrdy)
    );

    always @(negedge clk) begin
        if (st_eoa) eoa_cycles++;
        if (st_eoa && !eoa_prev) eoa_rises++;
        eoa_prev <= st_eoa;
    end

    function automatic bit exp_ack(input logic [6:0] a, input bit en);
        return en && (a == OWN);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start_c();
        sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
    endtask

    task automatic stop_c();
        sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(Q);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; wq(Q); scl_m = 1'b1; wq(2*Q); scl_m = 1'b0; wq(Q);
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); b = sda_bus; wq(Q); scl_m = 1'b0; wq(Q);
    endtask

    task automatic write_byte(input logic [7:0] d, output bit acked);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        get_bit(b);
        acked = !b;
    endtask

    task automatic cpu_thr(input logic [7:0] d);
        thr_data = d; thr_wr = 1'b1; @(negedge clk); thr_wr = 1'b0;
    endtask

    task automatic read_byte(output logic [7:0] d, input bit ack, input bit more,
                             input logic [7:0] nextd);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            d[i] = b;
        end
        sda_m = !ack; wq(Q); scl_m = 1'b1; wq(Q);
        if (more) begin
            chk("R5 txrdy after ack sample", st_txrdy, 1);
            cpu_thr(nextd);
            wq(Q - 1);
        end else begin
            wq(Q);
        end
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic cpu_rdr();
        rdr_rd = 1'b1; @(negedge clk); rdr_rd = 1'b0;
    endtask

    initial begin : watchdog
        repeat (WD_LIMIT) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog actual=%0d expected=<%0d cycles", WD_LIMIT, WD_LIMIT);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : main
        bit acked;
        logic [7:0] got;
        logic [7:0] d [4];
        int base;
        int seed_init;
        seed_init = $urandom(32'd5150);
        wq(4);
        rst_n = 1'b1;
        wq(4);

        // R1 reset values
        chk("R1 sda_oe", sda_oe, 0);
        chk("R1 access", st_access, 0);
        chk("R1 read", st_read, 0);
        chk("R1 eoa", st_eoa, 0);
        chk("R1 txrdy", st_txrdy, 1);
        chk("R1 txcomp", st_txcomp, 1);
        chk("R1 nack", st_nack, 0);
        chk("R1 rxrdy", st_rxrdy, 0);

        // R2/R3 directed write access
        start_c();
        write_byte({OWN, 1'b0}, acked);
        chk("R2 address ack", acked, 1);
        chk("R2 access", st_access, 1);
        chk("R2 direction write", st_read, 0);
        write_byte(8'hA5, acked);
        chk("R3 data ack", acked, 1);
        chk("R3 rxrdy set", st_rxrdy, 1);
        chk("R3 rdr_data", rdr_data, 8'hA5);
        cpu_rdr();
        chk("R3 rxrdy cleared", st_rxrdy, 0);
        write_byte(8'h00, acked);
        chk("R3 data ack zero byte", acked, 1);
        chk("R3 rdr_data zero", rdr_data, 8'h00);
        cpu_rdr();
        base = eoa_rises;
        stop_c();
        chk("R7 access dropped at stop", st_access, 0);
        chk("R7 one eoa at stop", eoa_rises - base, 1);
        chk("R8 txcomp kept after write", st_txcomp, 1);

        // R2 non-matching address
        start_c();
        write_byte({OWN ^ 7'h01, 1'b0}, acked);
        chk("R2 no ack on mismatch", acked, 0);
        chk("R2 access stays low", st_access, 0);
        base = eoa_rises;
        stop_c();
        chk("R7 no eoa without access", eoa_rises - base, 0);

        // R4/R5/R6/R8 directed read access, two bytes, last one NACKed
        cpu_thr(8'hC3);
        chk("R5 txrdy cleared by write", st_txrdy, 0);
        start_c();
        write_byte({OWN, 1'b1}, acked);
        chk("R2 read address ack", acked, 1);
        chk("R2 direction read", st_read, 1);
        chk("R8 txcomp cleared", st_txcomp, 0);
        read_byte(got, 1'b1, 1'b1, 8'h5E);
        chk("R4 first read byte", got, 8'hC3);
        read_byte(got, 1'b0, 1'b0, 8'h00);
        chk("R4 second read byte", got, 8'h5E);
        chk("R6 nack set", st_nack, 1);
        chk("R5 txrdy after nack", st_txrdy, 1);
        chk("R6 line released", sda_oe, 0);
        base = eoa_rises;
        stop_c();
        chk("R8 txcomp set at end", st_txcomp, 1);
        chk("R7 eoa at read end", eoa_rises - base, 1);

        // R7/R6 repeated START: write access, then read access
        start_c();
        write_byte({OWN, 1'b0}, acked);
        write_byte(8'h3C, acked);
        cpu_rdr();
        base = eoa_rises;
        cpu_thr(8'h81);
        start_c();
        chk("R7 access dropped at repeated start", st_access, 0);
        chk("R7 eoa at repeated start", eoa_rises - base, 1);
        write_byte({OWN, 1'b1}, acked);
        chk("R6 nack cleared by new match", st_nack, 0);
        chk("R7 access again", st_access, 1);
        read_byte(got, 1'b0, 1'b0, 8'h00);
        chk("R4 read after repeated start", got, 8'h81);
        stop_c();

        // R9 disabled by controller request and by enable
        ctl_en = 1'b1;
        start_c();
        write_byte({OWN, 1'b0}, acked);
        chk("R9 no ack with ctl_en", acked, 0);
        chk("R9 no access with ctl_en", st_access, 0);
        stop_c();
        ctl_en = 1'b0;
        tgt_en = 1'b0;
        start_c();
        write_byte({OWN, 1'b1}, acked);
        chk("R9 no ack with tgt_en low", acked, 0);
        chk("R9 no access with tgt_en low", st_access, 0);
        stop_c();
        tgt_en = 1'b1;

        // random transfers
        for (int it = 0; it < 8; it++) begin
            logic [6:0] a;
            bit rd;
            int n;
            a = ($urandom % 2) ? OWN : 7'($urandom);
            rd = 1'($urandom % 2);
            n = 1 + int'($urandom % 3);
            for (int k = 0; k < 4; k++) d[k] = 8'($urandom);
            if (rd) cpu_thr(d[0]);
            start_c();
            write_byte({a, rd}, acked);
            chk("R2 random address ack", acked, exp_ack(a, 1'b1));
            if (!exp_ack(a, 1'b1)) begin
                stop_c();
                chk("R2 random mismatch no access", st_access, 0);
                continue;
            end
            if (rd) begin
                for (int k = 0; k < n; k++) begin
                    read_byte(got, k < n - 1, k < n - 1, d[k+1]);
                    chk("R4 random read byte", got, d[k]);
                end
                chk("R6 random nack", st_nack, 1);
            end else begin
                for (int k = 0; k < n; k++) begin
                    write_byte(d[k], acked);
                    chk("R3 random write ack", acked, 1);
                    chk("R3 random rdr_data", rdr_data, d[k]);
                    cpu_rdr();
                end
            end
            base = eoa_rises;
            stop_c();
            chk("R7 random eoa", eoa_rises - base, 1);
            chk("R8 random txcomp", st_txcomp, 1);
        end

        chk("R7 eoa one cycle wide", eoa_cycles, eoa_rises);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule